// File: doc/BRIEF.md
# Modem Status Change Detector

This block keeps the modem status byte of a serial port. It watches four handshake lines and samples them on every clock. The upper half of the byte holds the level each line had at the last sample. The lower half holds one sticky change flag per line. When any line moves, the block raises a modem-status interrupt request. The host reads the byte through a one-cycle read strobe. That read clears the change flags and the request, and it leaves the line levels in place.

For self-test, a loopback control routes four modem-control output bits into the detector in place of the external pins. Loopback changes are caught and flagged exactly like pin changes. The pins are expected to be synchronised to the clock before they reach this block.

Top module: `mdm_status_det`

## Requirements
- R1: While reset is asserted and directly after it, `status_o` is 8'h00 and `irq_o` is 0.
- R2: One clock after a sample, `status_o[7:4]` equals the sampled lines. Line i appears at bit 4+i.
- R3: A sample in which line i differs from `status_o[4+i]` sets the change flag `status_o[i]` at the next clock.
- R4: A sample equal to `status_o[7:4]`, taken with no read strobe, leaves `status_o` unchanged and does not raise `irq_o`.
- R5: A sample that differs from `status_o[7:4]` drives `irq_o` to 1 at the next clock.
- R6: In the cycle the read strobe is high, `status_o` shows the whole byte. After that clock, with no new change, bits 3:0 are 0 and bits 7:4 are kept.
- R7: A read strobe clears `irq_o` at the next clock when no line changes in the same cycle.
- R8: While `loop_en` is 1, `loop_ctl[i]` replaces `line_in[i]` as the sample of line i. Changes on `line_in` then have no effect.
- R9: A line change sampled in the same cycle as a read strobe sets its change flag and `irq_o` at the next clock, despite the clear.
- R10: A change flag that is already set stays set when its line changes again before a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously |
| line_in | input | 4 | Synchronised handshake pins, line i at bit i |
| loop_en | input | 1 | Selects the loopback source |
| loop_ctl | input | 4 | Modem-control output bits used as the loopback source |
| rd_stb | input | 1 | One-cycle read of the status byte |
| status_o | output | 8 | {line levels, change flags} |
| irq_o | output | 1 | Modem-status interrupt request |

## Verification
The bound checker verifies on every clock that the level half tracks the selected source one cycle late. It also checks that a change raises the request, that a quiet sample with no read holds the byte, that a quiet read leaves the flags and the request cleared, and that a set flag never drops without a read. Some behaviours depend on specific orderings, so only the bench scenarios show them. These are flag stickiness across a change that reverts a line, a change landing in the read cycle, the pins being ignored while loopback is on, and the byte seen during the strobe cycle.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
  typedef enum logic {
    SRC_PINS = 1'b0,
    SRC_LOOP = 1'b1
  } mdm_src_e;
endpackage

// File: rtl/mdm_src_sel.sv
module mdm_src_sel
  import mdm_pkg::*;
#(
  parameter int N_LINES = 4
) (
  input  logic [N_LINES-1:0] line_in,
  input  logic [N_LINES-1:0] loop_ctl,
  input  logic               loop_en,
  output logic [N_LINES-1:0] smp_o
);
  mdm_src_e sel;

  always_comb begin
    sel = loop_en ? SRC_LOOP : SRC_PINS;
    case (sel)
      SRC_LOOP: smp_o = loop_ctl;
      default:  smp_o = line_in;
    endcase
  end
endmodule

// File: rtl/mdm_line_cell.sv
module mdm_line_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic smp,
  input  logic rd_clr,
  output logic lvl_q,
  output logic dlt_q,
  output logic chg_o
);
  logic lvl_en, dlt_en, dlt_d;

  // next state
  always_comb begin
    chg_o  = smp ^ lvl_q;
    lvl_en = chg_o;
    dlt_en = chg_o | rd_clr;
    dlt_d  = chg_o | (dlt_q & ~rd_clr);
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= 1'b0;
      dlt_q <= 1'b0;
    end else begin
      if (lvl_en) lvl_q <= smp;
      if (dlt_en) dlt_q <= dlt_d;
    end
  end
endmodule

// File: rtl/mdm_irq_req.sv
module mdm_irq_req (
  input  logic clk,
  input  logic rst_n,
  input  logic any_chg,
  input  logic rd_clr,
  output logic irq_q
);
  logic irq_en, irq_d;

  always_comb begin
    irq_en = any_chg | rd_clr;
    irq_d  = any_chg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      irq_q <= 1'b0;
    else if (irq_en) irq_q <= irq_d;
  end
endmodule

// File: rtl/mdm_status_det.sv
module mdm_status_det #(
  parameter int N_LINES = 4,
  localparam int STW    = 2 * N_LINES
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_LINES-1:0] line_in,
  input  logic               loop_en,
  input  logic [N_LINES-1:0] loop_ctl,
  input  logic               rd_stb,
  output logic [STW-1:0]     status_o,
  output logic               irq_o
);
  logic [N_LINES-1:0] smp, lvl, dlt, chg;

  mdm_src_sel #(.N_LINES(N_LINES)) u_src (
    .line_in  (line_in),
    .loop_ctl (loop_ctl),
    .loop_en  (loop_en),
    .smp_o    (smp)
  );

  for (genvar i = 0; i < N_LINES; i++) begin : g_line
    mdm_line_cell u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .smp    (smp[i]),
      .rd_clr (rd_stb),
      .lvl_q  (lvl[i]),
      .dlt_q  (dlt[i]),
      .chg_o  (chg[i])
    );
  end

  mdm_irq_req u_irq (
    .clk     (clk),
    .rst_n   (rst_n),
    .any_chg (|chg),
    .rd_clr  (rd_stb),
    .irq_q   (irq_o)
  );

  assign status_o = {lvl, dlt};
endmodule

// File: rtl/mdm_status_det_chk.sv
module mdm_status_det_chk #(
  parameter int N_LINES = 4,
  localparam int STW    = 2 * N_LINES
) (
  input logic               clk,
  input logic               rst_n,
  input logic [N_LINES-1:0] line_in,
  input logic               loop_en,
  input logic [N_LINES-1:0] loop_ctl,
  input logic               rd_stb,
  input logic [STW-1:0]     status_o,
  input logic               irq_o
);
  logic               armed;
  logic [N_LINES-1:0] src_w, up_w, lo_w;

  assign src_w = loop_en ? loop_ctl : line_in;
  assign up_w  = status_o[STW-1:N_LINES];
  assign lo_w  = status_o[N_LINES-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  // R1
  always @(negedge clk) begin
    if (!rst_n) reset_state_chk: assert (status_o == '0 && !irq_o);
  end

  // R2
  level_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> up_w == $past(src_w));

  // R4
  quiet_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && src_w == up_w && !rd_stb) |=> ($stable(status_o) && !$rose(irq_o)));

  // R5
  change_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && src_w != up_w) |=> irq_o);

  // R6
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rd_stb && src_w == up_w) |=> (lo_w == '0 && $stable(up_w)));

  // R7
  read_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && rd_stb && src_w == up_w) |=> !irq_o);

  // R10
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !rd_stb) |=> ((lo_w & $past(lo_w)) == $past(lo_w)));
endmodule

bind mdm_status_det mdm_status_det_chk #(.N_LINES(N_LINES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .line_in  (line_in),
  .loop_en  (loop_en),
  .loop_ctl (loop_ctl),
  .rd_stb   (rd_stb),
  .status_o (status_o),
  .irq_o    (irq_o)
);

// File: tb/tb_mdm_status_det.sv
module tb_mdm_status_det;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [3:0] line_in;
  logic       loop_en;
  logic [3:0] loop_ctl;
  logic       rd_stb;
  logic [7:0] status_o;
  logic       irq_o;
  int n_chk = 0;
  int n_err = 0;
  bit done  = 1'b0;

  always #10 clk = ~clk;

  mdm_status_det dut (
    .clk(clk), .rst_n(rst_n), .line_in(line_in), .loop_en(loop_en),
    .loop_ctl(loop_ctl), .rd_stb(rd_stb), .status_o(status_o), .irq_o(irq_o)
  );

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [7:0] st_exp, input logic irq_exp);
    n_chk++;
    if (status_o !== st_exp || irq_o !== irq_exp) begin
      n_err++;
      $display("FAIL %s: status=%h irq=%b, expected status=%h irq=%b",
               req, status_o, irq_o, st_exp, irq_exp);
    end
  endtask

  task automatic read_pulse(input string req, input logic [7:0] st_seen, input logic irq_seen);
    rd_stb = 1'b1;
    #1;
    chk(req, st_seen, irq_seen);
    tick();
    rd_stb = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; line_in = 4'h0; loop_en = 1'b0; loop_ctl = 4'h0; rd_stb = 1'b0;
    tick(); tick();
    chk("R1 during reset", 8'h00, 1'b0);
    rst_n = 1'b1;
    tick();
    chk("R1 after reset", 8'h00, 1'b0);
  endtask

  task automatic t_change_and_read();
    line_in = 4'b0101;
    tick();
    chk("R2 R3 R5 change", 8'h55, 1'b1);
    read_pulse("R6 byte during strobe", 8'h55, 1'b1);
    chk("R6 R7 read clears", 8'h50, 1'b0);
  endtask

  task automatic t_hold();
    tick(); tick();
    chk("R4 quiet hold", 8'h50, 1'b0);
  endtask

  task automatic t_sticky();
    line_in = 4'b0100;
    tick();
    chk("R3 fall flagged", 8'h41, 1'b1);
    line_in = 4'b0101;
    tick();
    chk("R10 flag sticky", 8'h51, 1'b1);
    read_pulse("R6 sticky read", 8'h51, 1'b1);
    chk("R6 sticky cleared", 8'h50, 1'b0);
  endtask

  task automatic t_same_cycle();
    line_in = 4'b1101;
    read_pulse("R6 pre-change read", 8'h50, 1'b0);
    chk("R9 change survives read", 8'hD8, 1'b1);
    read_pulse("R6 read", 8'hD8, 1'b1);
    chk("R7 cleared", 8'hD0, 1'b0);
  endtask

  task automatic t_loop();
    loop_ctl = 4'b1101;
    loop_en  = 1'b1;
    tick();
    chk("R8 loop same value", 8'hD0, 1'b0);
    line_in = 4'b0000;
    tick(); tick();
    chk("R8 pins ignored", 8'hD0, 1'b0);
    loop_ctl = 4'b0011;
    tick();
    chk("R8 loop change", 8'h3E, 1'b1);
    read_pulse("R8 loop read", 8'h3E, 1'b1);
    chk("R8 loop cleared", 8'h30, 1'b0);
    loop_en = 1'b0;
    tick();
    chk("R8 back to pins", 8'h03, 1'b1);
  endtask

  initial begin
    #2;
    t_reset();
    t_change_and_read();
    t_hold();
    t_sticky();
    t_same_cycle();
    t_loop();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (2000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule